// File: doc/BRIEF.md
# Selectable Byte Test-Pattern Source and Checker

This block produces a stream of bytes for exercising a serial link or any byte-wide data path. The stream follows one of three sequences: a plain counter, a Fibonacci series reduced modulo the byte width, or a reflected binary (Gray) code. A restart pulse captures the requested sequence and rewinds to its first value. A next pulse steps the stream to the following value. The current byte is always visible on the output.

A companion checker runs its own copy of the same sequence. Each byte offered on the receive side is compared with the value the sequence expects at that position. Mismatches are counted in a counter that saturates. The zero-based position of the first bad byte is held until the next restart. The checker always follows the sequence captured at the last restart, so the two ends of a loopback test stay matched.

Top module: `bytepat_engine`

## Requirements
- R1: After reset, tx_byte is 0x00, the active sequence is increment, err_count is 0 and first_err_idx is 0.
- R2: A restart pulse latches mode_sel (0 = increment, 1 = Fibonacci, 2 = Gray, 3 = increment). From the next cycle, tx_byte shows the first value of that sequence. A change of mode_sel without restart has no effect on tx_byte.
- R3: In increment mode, each next pulse makes tx_byte one greater than before, modulo 256, starting from 0x00.
- R4: In Fibonacci mode, the values are 0, 1, 1, 2, 3, 5, 8, 13, …. Each value from the third on is the sum of the two before it, modulo 256.
- R5: In Gray mode, the value at step n is n XOR (n >> 1), with n an 8-bit count. Consecutive values differ in exactly one bit, and this includes the wrap from 0x80 back to 0x00. The least significant bit runs 0, 1, 1, 0 repeating.
- R6: In a cycle with neither next nor restart, tx_byte holds its value.
- R7: When restart and next are high in the same cycle, restart wins: tx_byte shows the first value of the sequence.
- R8: On each rx_valid cycle without restart, the checker compares rx_byte with the value of the latched sequence at the receive position, then advances that position. A mismatch raises err_count by one in the next cycle.
- R9: err_count saturates at its all-ones value and never wraps.
- R10: first_err_idx holds the zero-based receive position of the first mismatch since the last restart. Later mismatches do not change it.
- R11: Restart clears err_count, first_err_idx and the receive position. An rx_valid in the same cycle as restart is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested sequence, latched on restart |
| restart | input | 1 | Rewind both sequences and clear the checker |
| next_req | input | 1 | Step the transmit sequence |
| tx_byte | output | PW | Current transmit value |
| rx_valid | input | 1 | rx_byte is to be checked this cycle |
| rx_byte | input | PW | Received byte |
| err_count | output | CW | Saturating mismatch count |
| first_err_idx | output | IW | Position of the first mismatch |

## Verification
The bench steps a Gray stream through a full cycle of 256 values and checks the single-bit change at every step, including the wrap. A design that forms the code wrongly, or that wraps to the wrong value, shows a two-bit jump at that step. The Fibonacci series is run past the byte limit, so a sum that saturates or drops its carry the wrong way gives values that diverge from the reference. The bench also offers more than 255 bad bytes to the checker. A counter that wraps returns to a small count, and a first-position latch that reloads on later errors moves away from its first value. Restart is driven together with next and with rx_valid, and mode_sel is changed without restart. These cases catch a wrong priority or an early mode capture, both of which corrupt the next byte.

// File: rtl/bytepat_pkg.sv
package bytepat_pkg;
  typedef enum logic [1:0] {
    PAT_INC  = 2'd0,
    PAT_FIB  = 2'd1,
    PAT_GRAY = 2'd2,
    PAT_RSV  = 2'd3
  } pat_mode_e;
endpackage

// File: rtl/bytepat_seq.sv
module bytepat_seq
  import bytepat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pat_mode_e    mode_sel,
  input  logic         restart,
  input  logic         adv,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] ONE = W'(1);

  pat_mode_e    mode_q, mode_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] fa_q, fa_d;
  logic [W-1:0] fb_q, fb_d;
  logic         load_en;

  assign load_en = restart | adv;

  // next-state
  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    fa_d   = fa_q;
    fb_d   = fb_q;
    if (restart) begin
      mode_d = mode_sel;
      cnt_d  = '0;
      fa_d   = '0;
      fb_d   = ONE;
    end else if (adv) begin
      cnt_d = cnt_q + ONE;
      fa_d  = fb_q;
      fb_d  = fa_q + fb_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PAT_INC;
      cnt_q  <= '0;
      fa_q   <= '0;
      fb_q   <= ONE;
    end else if (load_en) begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      fa_q   <= fa_d;
      fb_q   <= fb_d;
    end
  end

  // output select
  always_comb begin
    case (mode_q)
      PAT_FIB:  value = fa_q;
      PAT_GRAY: value = cnt_q ^ (cnt_q >> 1);
      default:  value = cnt_q;
    endcase
  end

  p_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && fa_q == '0 && fb_q == ONE));

  p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && mode_q != PAT_FIB && mode_q != PAT_GRAY)
      |=> value == W'($past(value) + ONE));

  p_fib_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && mode_q == PAT_FIB)
      |=> fb_q == W'(value + $past(value)));

  p_gray_onebit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && mode_q == PAT_GRAY)
      |=> $countones(value ^ $past(value)) == 1);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(value));
endmodule

// File: rtl/bytepat_chk.sv
module bytepat_chk #(
  parameter int W  = 8,
  parameter int CW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_byte,
  input  logic [W-1:0]  exp_byte,
  output logic          accept,
  output logic [CW-1:0] err_count,
  output logic [IW-1:0] first_idx
);
  localparam logic [CW-1:0] ERR_MAX = '1;
  localparam logic [CW-1:0] ERR_ONE = CW'(1);
  localparam logic [IW-1:0] IDX_ONE = IW'(1);

  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] err_q, err_d;
  logic [IW-1:0] first_q, first_d;
  logic          miss;
  logic          upd_en;

  assign accept = rx_valid & ~restart;
  assign miss   = accept & (rx_byte != exp_byte);
  assign upd_en = restart | accept;

  // next-state
  always_comb begin
    idx_d   = idx_q;
    err_d   = err_q;
    first_d = first_q;
    if (restart) begin
      idx_d   = '0;
      err_d   = '0;
      first_d = '0;
    end else if (accept) begin
      idx_d = idx_q + IDX_ONE;
      if (miss) begin
        if (err_q == '0) first_d = idx_q;
        if (err_q != ERR_MAX) err_d = err_q + ERR_ONE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      err_q   <= '0;
      first_q <= '0;
    end else if (upd_en) begin
      idx_q   <= idx_d;
      err_q   <= err_d;
      first_q <= first_d;
    end
  end

  assign err_count = err_q;
  assign first_idx = first_q;

  p_count_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_byte != exp_byte && err_q != ERR_MAX) |=> err_q == $past(err_q) + ERR_ONE);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && err_q == ERR_MAX) |=> err_q == ERR_MAX);

  p_first_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && err_q != '0) |=> $stable(first_q));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (err_q == '0 && first_q == '0 && idx_q == '0));
endmodule

// File: rtl/bytepat_engine.sv
module bytepat_engine
  import bytepat_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          restart,
  input  logic          next_req,
  output logic [PW-1:0] tx_byte,
  input  logic          rx_valid,
  input  logic [PW-1:0] rx_byte,
  output logic [CW-1:0] err_count,
  output logic [IW-1:0] first_err_idx
);
  pat_mode_e     mode_e;
  logic [PW-1:0] exp_byte;
  logic          rx_accept;

  assign mode_e = pat_mode_e'(mode_sel);

  bytepat_seq #(.W(PW)) u_tx_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_e),
    .restart  (restart),
    .adv      (next_req),
    .value    (tx_byte)
  );

  bytepat_seq #(.W(PW)) u_rx_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_e),
    .restart  (restart),
    .adv      (rx_accept),
    .value    (exp_byte)
  );

  bytepat_chk #(.W(PW), .CW(CW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .exp_byte  (exp_byte),
    .accept    (rx_accept),
    .err_count (err_count),
    .first_idx (first_err_idx)
  );

  p_restart_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && next_req) |=> tx_byte == '0);
endmodule

// File: tb/bytepat_engine_test.sv
module bytepat_engine_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       restart, next_req, rx_valid;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte;
  logic [7:0] err_count;
  logic [15:0] first_err_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int g_mode = 0, g_n = 0, c_mode = 0, c_n = 0, e_cnt = 0, e_first = 0;

  always #5 clk = ~clk;

  bytepat_engine uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .restart(restart),
    .next_req(next_req), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .err_count(err_count), .first_err_idx(first_err_idx)
  );

  function automatic int ref_val(int m, int n);
    int a = 0, b = 1, t;
    if (m == 1) begin
      for (int i = 0; i < n; i++) begin t = (a + b) % 256; a = b; b = t; end
      return a;
    end else if (m == 2) begin
      return (n % 256) ^ ((n % 256) >> 1);
    end
    return n % 256;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle from a negedge; update the model; return at the next negedge
  task automatic cyc(bit rs, bit nx, bit rv, int rb, int ms);
    restart = rs; next_req = nx; rx_valid = rv; rx_byte = rb[7:0]; mode_sel = ms[1:0];
    if (rs) begin
      g_mode = (ms == 3) ? 0 : ms; c_mode = g_mode;
      g_n = 0; c_n = 0; e_cnt = 0; e_first = 0;
    end else begin
      if (nx) g_n++;
      if (rv) begin
        if (rb != ref_val(c_mode, c_n)) begin
          if (e_cnt == 0) e_first = c_n;
          if (e_cnt != 255) e_cnt++;
        end
        c_n++;
      end
    end
    @(negedge clk);
    restart = 0; next_req = 0; rx_valid = 0;
  endtask

  task automatic check_all(string tag);
    check({tag, " tx_byte"}, tx_byte, ref_val(g_mode, g_n));
    check({tag, " err_count"}, err_count, e_cnt);
    check({tag, " first_err_idx"}, first_err_idx, e_first);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    void'($urandom(32'h5eed1234));
    rst_n = 0; restart = 0; next_req = 0; rx_valid = 0; rx_byte = 0; mode_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_byte", tx_byte, 0);
    check("R1 err_count", err_count, 0);
    check("R1 first_err_idx", first_err_idx, 0);

    // R3 increment with wrap
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 260; i++) begin
      cyc(0, 1, 0, 0, 0);
      check("R3 increment", tx_byte, (i + 1) % 256);
    end

    // R2 mode change without restart ignored, R6 hold
    cyc(0, 0, 0, 0, 1);
    check("R2 mode_sel ignored", tx_byte, 4);
    cyc(0, 1, 0, 0, 2);
    check("R2 still increment", tx_byte, 5);
    cyc(0, 0, 0, 0, 2);
    check("R6 hold", tx_byte, 5);

    // R4 Fibonacci, past byte limit
    cyc(1, 0, 0, 0, 1);
    check("R2 fib first value", tx_byte, 0);
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 0, 0, 1);
      check("R4 fibonacci", tx_byte, ref_val(1, i + 1));
    end
    check("R4 step 7 value", ref_val(1, 7), 13);

    // R5 Gray full cycle and wrap
    cyc(1, 0, 0, 0, 2);
    prev = tx_byte;
    for (int i = 0; i < 256; i++) begin
      cyc(0, 1, 0, 0, 2);
      check("R5 gray one-bit step", $countones(8'(tx_byte ^ prev[7:0])), 1);
      check("R5 gray value", tx_byte, ref_val(2, i + 1));
      check("R5 gray lsb 0110", tx_byte[0], ((i + 1) % 4 == 1 || (i + 1) % 4 == 2) ? 1 : 0);
      prev = tx_byte;
    end
    check("R5 gray wrap to zero", tx_byte, 0);

    // R7 restart beats next
    cyc(0, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 3);
    check("R7 restart priority", tx_byte, 0);

    // R8 checker in Fibonacci, good then bad bytes
    cyc(1, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, ref_val(1, i), 1);
    check_all("R8 clean stream");
    cyc(0, 0, 1, 8'hAA, 1);
    check("R8 mismatch counted", err_count, 1);
    check("R10 first index", first_err_idx, 6);

    // R9 saturation, R10 first index kept
    for (int i = 0; i < 300; i++) cyc(0, 0, 1, ref_val(1, c_n) ^ 1, 1);
    check("R9 saturate", err_count, 255);
    check("R10 first index kept", first_err_idx, 6);

    // R11 restart clears, rx in same cycle ignored
    cyc(1, 0, 1, 8'h55, 2);
    check("R11 cleared count", err_count, 0);
    check("R11 cleared index", first_err_idx, 0);
    cyc(0, 0, 1, 0, 2);
    check("R11 position restarted", err_count, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit rs = ($urandom % 40) == 0;
      bit nx = $urandom % 2;
      bit rv = $urandom % 2;
      int ms = $urandom % 4;
      int rb = ref_val(c_mode, c_n);
      if (($urandom % 10) == 0) rb = rb ^ (1 << ($urandom % 8));
      cyc(rs, nx, rv, rb, ms);
      check_all("R8 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule